// File: doc/BRIEF.md
# Method Address Generator and Emitter

This block keeps the target address of the outgoing method stream for a command macro engine. A set strobe carries one packed 32-bit word. Its low field becomes the current byte address, and the next four bits become a per-emit stride. Each emit strobe that is accepted stores a data word into a shadow-state RAM at the current address. The address then moves forward by the stride, counted in 32-bit words.

Emits are dropped while no address has been loaded since reset. A set and an emit may arrive together. In that case the set takes effect first, so the word goes to the freshly loaded address. One variant of the emit stores a small field of the set word, zero-extended, in place of the emit data. The RAM write port and the completion pulse are registered. A per-address hook vector flags writes to addresses that carry side effects.

Top module: `mae_emitter`

## Requirements
- R1: While reset is low, and in the first cycle after it, ram_we_o, emit_done_o and hook_o are all zero. Reset also clears the loaded flag, so an emit after reset is dropped until a new set arrives.
- R2: A set strobe loads the current byte address with set_val_i[11:0] shifted left by two, with the upper bits zero.
- R3: A set strobe loads the stride from set_val_i[15:12]. Each accepted emit then adds stride×4 to the address, so a stride of zero repeats the same address.
- R4: An emit strobe that arrives before any set since reset produces no write and no completion pulse, and it leaves the address unchanged.
- R5: An accepted emit in cycle t drives ram_we_o high in cycle t+1. In that cycle ram_addr_o holds the address used and ram_data_o holds the data word. A cycle with no emit gives no write in the next cycle.
- R6: The address is 16 bits wide and wraps modulo 65536 when it is advanced.
- R7: When set_i and emit_i are high in the same cycle, the emit uses the newly loaded address and stride. The address that follows is the new address plus the new stride×4.
- R8: When emit_hi_i is high with emit_i, the stored data word is set_val_i[17:12] of that cycle, zero-extended to 32 bits, in place of emit_data_i.
- R9: hook_o[k] is high together with ram_we_o exactly when ram_addr_o equals entry k of HOOK_ADDRS. The default entries are 0x0C00 for bit 0 and 0x1B0C for bit 1.
- R10: emit_done_o is a one-cycle pulse for each accepted emit, and it is aligned with ram_we_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | 1 | Load address and stride from set_val_i |
| set_val_i | input | 32 | Packed address/stride word |
| emit_i | input | 1 | Emit one data word |
| emit_data_i | input | 32 | Data word for an emit |
| emit_hi_i | input | 1 | Use set_val_i[17:12] as the emit data |
| ram_we_o | output | 1 | Shadow RAM write enable |
| ram_addr_o | output | 16 | Shadow RAM byte address |
| ram_data_o | output | 32 | Shadow RAM write data |
| emit_done_o | output | 1 | Completion pulse for an accepted emit |
| hook_o | output | N_HOOK | Side-effect address hit, one bit per entry |

## Verification
The two functions that can coincide are a set-address load and an emit. The random phase raises both strobes in the same cycle often, and the directed phase also includes a combined set and high-field emit. The bench judges the combined case by the address on the write port, which must be the newly loaded one. The address written by the next emit must be that address plus the new stride. Its expected values come from a reference model in the bench that applies the set before the emit.

// File: rtl/mae_pkg.sv
package mae_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned FIELD_W  = 12;
  localparam int unsigned STRIDE_W = 4;
  localparam int unsigned HI_LSB   = 12;
  localparam int unsigned HI_W     = 6;
  localparam int unsigned N_HOOK   = 2;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/mae_addr_track.sv
module mae_addr_track #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned FIELD_W  = 12,
  parameter int unsigned STRIDE_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        set_i,
  input  logic [FIELD_W+STRIDE_W-1:0] set_val_i,
  input  logic                        emit_i,
  output logic                        accept_o,
  output logic [ADDR_W-1:0]           wr_addr_o
);
  localparam int unsigned PAD_A = ADDR_W - FIELD_W - 2;
  localparam int unsigned PAD_S = ADDR_W - STRIDE_W - 2;

  logic                valid_q;
  logic [ADDR_W-1:0]   addr_q, addr_d, new_addr, base_addr, step;
  logic [STRIDE_W-1:0] stride_q, new_stride, base_stride;

  assign new_addr    = {{PAD_A{1'b0}}, set_val_i[FIELD_W-1:0], 2'b00};
  assign new_stride  = set_val_i[FIELD_W+STRIDE_W-1:FIELD_W];
  // set applies before a same-cycle emit
  assign base_addr   = set_i ? new_addr : addr_q;
  assign base_stride = set_i ? new_stride : stride_q;
  assign step        = {{PAD_S{1'b0}}, base_stride, 2'b00};
  assign accept_o    = emit_i && (valid_q || set_i);
  assign wr_addr_o   = base_addr;
  assign addr_d      = accept_o ? base_addr + step : base_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      addr_q   <= '0;
      stride_q <= '0;
    end else begin
      valid_q  <= valid_q | set_i;
      addr_q   <= addr_d;
      stride_q <= base_stride;
    end
  end

  // R2
  set_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !emit_i) |=> addr_q == {{PAD_A{1'b0}}, $past(set_val_i[FIELD_W-1:0]), 2'b00});

  // R3
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_i && valid_q && !set_i) |=>
      addr_q == $past(addr_q) + {{PAD_S{1'b0}}, $past(stride_q), 2'b00});

  // R4
  drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_q && !set_i) |=> $stable(addr_q));

  // R7
  set_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && emit_i) |=>
      addr_q == {{PAD_A{1'b0}}, $past(set_val_i[FIELD_W-1:0]), 2'b00}
              + {{PAD_S{1'b0}}, $past(set_val_i[FIELD_W+STRIDE_W-1:FIELD_W]), 2'b00});
endmodule

// File: rtl/mae_data_sel.sv
module mae_data_sel #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HI_W   = 6
) (
  input  logic              hi_sel_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [HI_W-1:0]   hi_field_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] hi_ext;

  generate
    if (HI_W >= DATA_W) begin : g_trunc
      assign hi_ext = hi_field_i[DATA_W-1:0];
    end else begin : g_zext
      assign hi_ext = {{(DATA_W-HI_W){1'b0}}, hi_field_i};
    end
  endgenerate

  assign data_o = hi_sel_i ? hi_ext : data_i;
endmodule

// File: rtl/mae_hook_match.sv
module mae_hook_match #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned N_HOOK = 2,
  parameter logic [N_HOOK*ADDR_W-1:0] HOOK_ADDRS = {16'h1B0C, 16'h0C00}
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_HOOK-1:0] hit_o
);
  for (genvar k = 0; k < N_HOOK; k++) begin : g_cmp
    assign hit_o[k] = we_i && (addr_i == HOOK_ADDRS[k*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/mae_emitter.sv
module mae_emitter
  import mae_pkg::*;
#(
  parameter int unsigned ADDR_W   = mae_pkg::ADDR_W,
  parameter int unsigned DATA_W   = mae_pkg::DATA_W,
  parameter int unsigned FIELD_W  = mae_pkg::FIELD_W,
  parameter int unsigned STRIDE_W = mae_pkg::STRIDE_W,
  parameter int unsigned HI_LSB   = mae_pkg::HI_LSB,
  parameter int unsigned HI_W     = mae_pkg::HI_W,
  parameter int unsigned N_HOOK   = mae_pkg::N_HOOK,
  parameter logic [N_HOOK*ADDR_W-1:0] HOOK_ADDRS = {16'h1B0C, 16'h0C00}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [DATA_W-1:0] set_val_i,
  input  logic              emit_i,
  input  logic [DATA_W-1:0] emit_data_i,
  input  logic              emit_hi_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              emit_done_o,
  output logic [N_HOOK-1:0] hook_o
);
  localparam int unsigned SET_USED = FIELD_W + STRIDE_W;

  logic              accept;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [N_HOOK-1:0] hit;
  logic              unused_setval;
  wr_req_t           req_q;
  logic              done_q;
  logic [N_HOOK-1:0] hook_q;

  assign unused_setval = ^set_val_i[DATA_W-1:HI_LSB+HI_W];

  mae_addr_track #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .STRIDE_W(STRIDE_W)
  ) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_i),
    .set_val_i (set_val_i[SET_USED-1:0]),
    .emit_i    (emit_i),
    .accept_o  (accept),
    .wr_addr_o (wr_addr)
  );

  mae_data_sel #(.DATA_W(DATA_W), .HI_W(HI_W)) u_dsel (
    .hi_sel_i   (emit_hi_i),
    .data_i     (emit_data_i),
    .hi_field_i (set_val_i[HI_LSB+HI_W-1:HI_LSB]),
    .data_o     (wr_data)
  );

  mae_hook_match #(
    .ADDR_W(ADDR_W), .N_HOOK(N_HOOK), .HOOK_ADDRS(HOOK_ADDRS)
  ) u_hook (
    .we_i   (accept),
    .addr_i (wr_addr),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      done_q <= 1'b0;
      hook_q <= '0;
    end else begin
      req_q.we <= accept;
      done_q   <= accept;
      hook_q   <= hit;
      if (accept) begin
        req_q.addr <= wr_addr;
        req_q.data <= wr_data;
      end
    end
  end

  assign ram_we_o    = req_q.we;
  assign ram_addr_o  = req_q.addr;
  assign ram_data_o  = req_q.data;
  assign emit_done_o = done_q;
  assign hook_o      = hook_q;

  // R5
  no_emit_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !emit_i |=> !ram_we_o);

  // R9
  hook_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hook_o) |-> ram_we_o);

  // R8
  hi_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emit_i && emit_hi_i && set_i) |=>
      ram_data_o == {{(DATA_W-HI_W){1'b0}}, $past(set_val_i[HI_LSB+HI_W-1:HI_LSB])});
endmodule

// File: tb/tb_mae_emitter.sv
`timescale 1ns/1ps
module tb_mae_emitter;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        set_i = 1'b0;
  logic [31:0] set_val_i = '0;
  logic        emit_i = 1'b0;
  logic [31:0] emit_data_i = '0;
  logic        emit_hi_i = 1'b0;
  logic        ram_we_o;
  logic [15:0] ram_addr_o;
  logic [31:0] ram_data_o;
  logic        emit_done_o;
  logic [1:0]  hook_o;

  int checks = 0;
  int fails = 0;

  logic        m_valid;
  logic [15:0] m_addr;
  logic [3:0]  m_stride;

  always #2.5 clk = ~clk;

  mae_emitter dut (
    .clk_i(clk), .rst_ni(rst_ni), .set_i(set_i), .set_val_i(set_val_i),
    .emit_i(emit_i), .emit_data_i(emit_data_i), .emit_hi_i(emit_hi_i),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o),
    .emit_done_o(emit_done_o), .hook_o(hook_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_hook(input logic [15:0] a);
    return {a == 16'h1B0C, a == 16'h0C00};
  endfunction

  // drive one cycle at a falling edge, check outputs at the next falling edge
  task automatic step(input bit s, input logic [31:0] sv, input bit e,
                      input logic [31:0] ed, input bit hi, input string tag);
    logic        ewe;
    logic [15:0] ea;
    logic [31:0] edat;
    set_i = s; set_val_i = sv; emit_i = e; emit_data_i = ed; emit_hi_i = hi;
    if (s) begin
      m_addr = {2'b00, sv[11:0], 2'b00};
      m_stride = sv[15:12];
      m_valid = 1'b1;
    end
    ewe  = e && m_valid;
    ea   = m_addr;
    edat = hi ? {26'd0, sv[17:12]} : ed;
    if (ewe) m_addr = m_addr + {10'd0, m_stride, 2'b00};
    @(negedge clk);
    chk(ram_we_o == ewe, {tag, " we"}, {31'd0, ram_we_o}, {31'd0, ewe});
    chk(emit_done_o == ewe, {tag, " R10 done"}, {31'd0, emit_done_o}, {31'd0, ewe});
    if (ewe) begin
      chk(ram_addr_o == ea, {tag, " addr"}, {16'd0, ram_addr_o}, {16'd0, ea});
      chk(ram_data_o == edat, {tag, " data"}, ram_data_o, edat);
      chk(hook_o == exp_hook(ea), {tag, " R9 hook"}, {30'd0, hook_o}, {30'd0, exp_hook(ea)});
    end else begin
      chk(hook_o == 2'b00, {tag, " R9 hook idle"}, {30'd0, hook_o}, 32'd0);
    end
    set_i = 0; emit_i = 0; emit_hi_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    set_i = 0; emit_i = 0; emit_hi_i = 0;
    m_valid = 0; m_addr = '0; m_stride = '0;
    repeat (2) @(negedge clk);
    chk(!ram_we_o && !emit_done_o && hook_o == 2'b00, "R1 reset outputs",
        {29'd0, ram_we_o, hook_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!ram_we_o && !emit_done_o, "R1 after release", {31'd0, ram_we_o}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    @(negedge clk);
    do_reset();

    // R4: emits before any set are dropped
    step(0, 32'h0, 1, 32'hDEAD_0001, 0, "R4");
    step(0, 32'h0, 1, 32'hDEAD_0002, 0, "R4");
    // R2 / R3: load 0x14, stride 2
    step(1, 32'h0000_2005, 0, 32'h0, 0, "R2");
    step(0, 32'h0, 1, 32'h1111_1111, 0, "R3 R5");
    step(0, 32'h0, 1, 32'h2222_2222, 0, "R3 R5");
    // stride zero repeats
    step(1, 32'h0000_0010, 0, 32'h0, 0, "R2");
    step(0, 32'h0, 1, 32'h3333_3333, 0, "R3 stride0");
    step(0, 32'h0, 1, 32'h4444_4444, 0, "R3 stride0");
    // R7: set and emit together
    step(1, 32'h0000_3100, 1, 32'h5555_5555, 0, "R7");
    step(0, 32'h0, 1, 32'h6666_6666, 0, "R7 follow");
    // R8: high field variant with set
    step(1, 32'h0002_A123, 1, 32'hFFFF_FFFF, 1, "R8 R7");
    step(0, 32'h0003_F000, 1, 32'hFFFF_FFFF, 1, "R8");
    // R9: hook addresses
    step(1, 32'h0000_1300, 1, 32'h7, 0, "R9 hook0");
    step(1, 32'h0000_06C3, 1, 32'h8, 0, "R9 hook1");
    // R6: wrap past 0xFFFF with stride 15
    step(1, 32'h0000_FFFF, 0, 32'h0, 0, "R2");
    for (int i = 0; i < 900; i++) step(0, 32'h0, 1, i, 0, "R6 wrap");
    // R1: reset mid-run clears loaded flag
    do_reset();
    step(0, 32'h0, 1, 32'h9, 0, "R1 R4 post-reset drop");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] sv;
      bit s, e, h;
      sv = $urandom;
      case ($urandom_range(0, 5))
        0: sv[11:0] = 12'h300;
        1: sv[11:0] = 12'h6C3;
        default: ;
      endcase
      s = ($urandom_range(0, 5) == 0);
      e = ($urandom_range(0, 1) == 1);
      h = ($urandom_range(0, 7) == 0);
      step(s, sv, e, $urandom, h, (s && e) ? "R7 rand" : "R5 rand");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule